// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their fill levels and push/pop strobes into status flags, interrupt requests and DMA requests. The FIFOs are outside the block. Only their current levels, the push and pop strobes, and a contention event from the bus logic come in. Threshold, watermark, mask and DMA-enable values arrive as plain configuration inputs.

Six raw flags are kept. Two of them follow the FIFO levels: transmit-low and receive-ready. Four are sticky error flags: transmit overflow, receive underflow, receive overflow and bus contention. Each error flag stays set until the read strobe of its own clear register is pulsed. The raw flags are ANDed with a mask and ORed into one interrupt line. The DMA requests are compared against watermarks that are separate from the interrupt thresholds. Every output is registered, so each one reflects the inputs sampled at the previous clock edge.

Raw and masked flag bit positions: 0 transmit-low, 1 transmit overflow, 2 receive underflow, 3 receive overflow, 4 receive-ready, 5 contention. The clear strobe vector uses the same bit positions.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Raw bit 0 is 1 one cycle after the transmit level is less than or equal to the transmit threshold, and 0 otherwise.
- R2: Raw bit 4 is 1 one cycle after the receive level is greater than the receive threshold. A threshold of 0 therefore means the receive FIFO is not empty.
- R3: The masked status equals the raw flags ANDed with the mask, and the interrupt line is the OR of the masked status, both on the same cycle as the raw flags. A mask of 0 keeps the interrupt line low.
- R4: Error flags (bits 1, 2, 3, 5) stay set until their own clear strobe bit is pulsed. Clear strobe bits 0 and 4 have no effect.
- R5: When a flag's set event and its clear strobe occur in the same cycle, the flag remains set.
- R6: Bit 1 sets on a transmit push while the transmit level equals DEPTH. Bit 2 sets on a receive pop while the receive level is 0. Bit 3 sets on a receive push while the receive level equals DEPTH. Bit 5 sets on a contention pulse. A push or pop that does not meet these conditions sets nothing.
- R7: The transmit-not-full output is 1 one cycle after the transmit level is below DEPTH.
- R8: The transmit DMA request is 1 one cycle after DMA enable bit 1 is set and the transmit level is at or below the transmit watermark.
- R9: The receive DMA request is 1 one cycle after DMA enable bit 0 is set and the receive level is strictly above the receive watermark.
- R10: While reset is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_push | input | 1 | Write into transmit FIFO |
| rx_push | input | 1 | Write into receive FIFO |
| rx_pop | input | 1 | Read from receive FIFO |
| bus_conflict | input | 1 | Contention event pulse |
| tx_thresh | input | LVL_W | Transmit-low threshold |
| rx_thresh | input | LVL_W | Receive-ready threshold |
| irq_mask | input | 6 | Per-source enable, 1 = unmasked |
| clr_rd | input | 6 | Clear-register read strobes, per flag bit |
| dma_en | input | 2 | Bit 0 receive DMA enable, bit 1 transmit DMA enable |
| tx_wmark | input | LVL_W | Transmit DMA watermark |
| rx_wmark | input | LVL_W | Receive DMA watermark |
| raw_status | output | 6 | Raw flags |
| masked_status | output | 6 | Raw flags ANDed with mask |
| irq | output | 1 | Combined interrupt |
| tx_not_full | output | 1 | Transmit FIFO not full |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest case to reach is a set event and a clear strobe landing on the same edge. The other hard case is a clear strobe on a bit that has no stored state. The bench first parks the transmit or receive level at its limit so that a single push or pop counts as an error. It then pulses that strobe together with the matching clear bit in one cycle, and pulses clear bits 0 and 4 while an error flag is held. The flags are read on the following cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC  = 6;
  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;
  localparam int B_MST = 5;
endpackage

// File: rtl/spi_lvl_status.sv
module spi_lvl_status #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic [LVL_W-1:0] tx_wmark,
  input  logic [LVL_W-1:0] rx_wmark,
  input  logic [1:0]       dma_en,
  output logic             tx_low_c,
  output logic             rx_ready_c,
  output logic             tx_not_full,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  assign tx_low_c   = (tx_level <= tx_thresh);
  assign rx_ready_c = (rx_level > rx_thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_not_full <= 1'b0;
      tx_dma_req  <= 1'b0;
      rx_dma_req  <= 1'b0;
    end else begin
      tx_not_full <= (tx_level != FULL_LVL);
      tx_dma_req  <= dma_en[1] & (tx_level <= tx_wmark);
      rx_dma_req  <= dma_en[0] & (rx_level > rx_wmark);
    end
  end

  AST_TXDMA_OFF: assert property (@(posedge clk) disable iff (rst)
    !dma_en[1] |=> !tx_dma_req); // R8
  AST_RXDMA_OFF: assert property (@(posedge clk) disable iff (rst)
    !dma_en[0] |=> !rx_dma_req); // R9
  AST_TX_FULL: assert property (@(posedge clk) disable iff (rst)
    (tx_level == FULL_LVL) |=> !tx_not_full); // R7
endmodule

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_rd,
  output logic flag_d,
  output logic flag_q
);
  assign flag_d = set_evt | (flag_q & ~clr_rd);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_rd) |=> flag_q); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && !set_evt) |=> !flag_q); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q); // R5
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             bus_conflict,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic [5:0]       irq_mask,
  input  logic [5:0]       clr_rd,
  input  logic [1:0]       dma_en,
  input  logic [LVL_W-1:0] tx_wmark,
  input  logic [LVL_W-1:0] rx_wmark,
  output logic [5:0]       raw_status,
  output logic [5:0]       masked_status,
  output logic             irq,
  output logic             tx_not_full,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic             tx_low_c, rx_ready_c;
  logic [NSRC-1:0]  evt, raw_d, raw_q;

  spi_lvl_status #(.DEPTH(DEPTH), .LVL_W(LVL_W)) lvl_i (
    .clk(clk), .rst(rst),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_wmark(tx_wmark), .rx_wmark(rx_wmark), .dma_en(dma_en),
    .tx_low_c(tx_low_c), .rx_ready_c(rx_ready_c),
    .tx_not_full(tx_not_full), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  always_comb begin
    evt        = '0;
    evt[B_TXE] = tx_low_c;
    evt[B_RXF] = rx_ready_c;
    evt[B_TXO] = tx_push & (tx_level == FULL_LVL);
    evt[B_RXU] = rx_pop & (rx_level == '0);
    evt[B_RXO] = rx_push & (rx_level == FULL_LVL);
    evt[B_MST] = bus_conflict;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == B_TXE || g == B_RXF) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) raw_q[g] <= 1'b0;
        else     raw_q[g] <= evt[g];
      end
      assign raw_d[g] = evt[g];
    end else begin : g_sticky
      spi_sticky_flag flag_i (
        .clk(clk), .rst(rst), .set_evt(evt[g]), .clr_rd(clr_rd[g]),
        .flag_d(raw_d[g]), .flag_q(raw_q[g])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_status <= '0;
      irq           <= 1'b0;
    end else begin
      masked_status <= raw_d & irq_mask;
      irq           <= |(raw_d & irq_mask);
    end
  end

  assign raw_status = raw_q;

  AST_TXE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= tx_thresh) |=> raw_status[B_TXE]); // R1
  AST_RXF_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= rx_thresh) |=> !raw_status[B_RXF]); // R2
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == '0) |=> !irq); // R3
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (masked_status & ~raw_status) == '0); // R3
  AST_TXO_SET: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_level == FULL_LVL) |=> raw_status[B_TXO]); // R6
endmodule

// File: tb/spi_fifo_irq_unit_tb_top.sv
module spi_fifo_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LVL_W = 7;

  typedef struct packed {
    logic [6:0] txl, rxl, txt, rxt;
    logic [5:0] msk;
    logic [1:0] dma;
    logic [6:0] txw, rxw;
    logic [5:0] e_raw;
    logic       e_irq, e_txnf, e_txdma, e_rxdma;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{7'd0,  7'd0,  7'd1,  7'd0,  6'h00, 2'd0, 7'd35, 7'd1,  6'b000001, 1'b0, 1'b1, 1'b0, 1'b0},
    '{7'd10, 7'd1,  7'd1,  7'd0,  6'h11, 2'd3, 7'd35, 7'd1,  6'b010000, 1'b1, 1'b1, 1'b1, 1'b0},
    '{7'd64, 7'd5,  7'd63, 7'd5,  6'h3f, 2'd2, 7'd35, 7'd1,  6'b000000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{7'd35, 7'd2,  7'd40, 7'd1,  6'h01, 2'd1, 7'd35, 7'd1,  6'b010001, 1'b1, 1'b1, 1'b0, 1'b1},
    '{7'd36, 7'd64, 7'd36, 7'd63, 6'h10, 2'd3, 7'd35, 7'd63, 6'b010001, 1'b1, 1'b1, 1'b0, 1'b1},
    '{7'd0,  7'd0,  7'd0,  7'd0,  6'h3f, 2'd3, 7'd0,  7'd0,  6'b000001, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [6:0] tx_level = '0, rx_level = '0, tx_thresh = '0, rx_thresh = '0;
  logic [6:0] tx_wmark = '0, rx_wmark = '0;
  logic tx_push = 0, rx_push = 0, rx_pop = 0, bus_conflict = 0;
  logic [5:0] irq_mask = '0, clr_rd = '0;
  logic [1:0] dma_en = '0;
  logic [5:0] raw_status, masked_status;
  logic irq, tx_not_full, tx_dma_req, rx_dma_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_irq_unit #(.DEPTH(DEPTH), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .bus_conflict(bus_conflict),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_mask(irq_mask), .clr_rd(clr_rd),
    .dma_en(dma_en), .tx_wmark(tx_wmark), .rx_wmark(rx_wmark),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq),
    .tx_not_full(tx_not_full), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: outputs held at zero during reset
    tx_thresh = 7'd1; irq_mask = 6'h3f; dma_en = 2'd3; tx_wmark = 7'd35;
    step(); step();
    chk("R10 raw", raw_status, 6'd0);
    chk("R10 misc", {masked_status[3:0], irq, tx_not_full}, 6'd0);
    chk("R10 dma", {4'd0, tx_dma_req, rx_dma_req}, 6'd0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R7 R8 R9
    for (int i = 0; i < 6; i++) begin
      tx_level = TBL[i].txl; rx_level = TBL[i].rxl;
      tx_thresh = TBL[i].txt; rx_thresh = TBL[i].rxt;
      irq_mask = TBL[i].msk; dma_en = TBL[i].dma;
      tx_wmark = TBL[i].txw; rx_wmark = TBL[i].rxw;
      step();
      chk("R1/R2 raw", raw_status, TBL[i].e_raw);
      chk("R3 masked", masked_status, TBL[i].e_raw & TBL[i].msk);
      chk("R3 irq", {5'd0, irq}, {5'd0, TBL[i].e_irq});
      chk("R7 txnf", {5'd0, tx_not_full}, {5'd0, TBL[i].e_txnf});
      chk("R8 txdma", {5'd0, tx_dma_req}, {5'd0, TBL[i].e_txdma});
      chk("R9 rxdma", {5'd0, rx_dma_req}, {5'd0, TBL[i].e_rxdma});
    end

    // error flags: level flags kept off
    tx_thresh = 7'd0; rx_thresh = 7'd64; irq_mask = 6'b000010; dma_en = 2'd0;
    tx_level = 7'd63; tx_push = 1;
    step(); tx_push = 0;
    chk("R6 push not full", raw_status, 6'd0);
    tx_level = 7'd64; tx_push = 1;
    step(); tx_push = 0;
    chk("R6 tx overflow", raw_status, 6'b000010);
    chk("R3 irq on txo", {5'd0, irq}, 6'd1);
    step();
    chk("R4 hold", raw_status, 6'b000010);
    clr_rd = 6'b010001;
    step(); clr_rd = 0;
    chk("R4 ignored clear bits", raw_status, 6'b000010);
    clr_rd = 6'b000010;
    step(); clr_rd = 0;
    chk("R4 cleared", raw_status, 6'd0);
    chk("R3 irq drop", {5'd0, irq}, 6'd0);
    step();
    tx_push = 1; clr_rd = 6'b000010;
    step(); tx_push = 0; clr_rd = 0;
    chk("R5 set wins", raw_status, 6'b000010);
    clr_rd = 6'b000010; step(); clr_rd = 0;

    rx_level = 7'd0; rx_pop = 1;
    step(); rx_pop = 0;
    chk("R6 rx underflow", raw_status, 6'b000100);
    rx_level = 7'd64; rx_push = 1;
    step(); rx_push = 0;
    chk("R6 rx overflow", raw_status, 6'b001100);
    bus_conflict = 1;
    step(); bus_conflict = 0;
    chk("R6 contention", raw_status, 6'b101100);
    clr_rd = 6'b000100;
    step(); clr_rd = 0;
    chk("R4 clear rxu only", raw_status, 6'b101000);
    irq_mask = 6'b100000;
    step();
    chk("R3 masked contention", masked_status, 6'b100000);
    clr_rd = 6'b101000;
    step(); clr_rd = 0;
    chk("R4 clear rest", raw_status, 6'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule